// File: doc/BRIEF.md
# Read-Sequence Store Trigger Detector

This block sits beside the control and address pins of a byte-wide static memory with an 11-bit address. It lets software ask for a nonvolatile save using only read accesses, so the memory keeps a plain SRAM interface. The block samples the enable, output-enable, write-enable and address lines on every clock. It works out where each read access begins. It then compares the run of read addresses with a fixed six-step key. Once the final key read is seen, it raises a one-cycle store request to a separate store sequencer.

Any read that breaks the key order, or any write, drops the attempt in progress. A read of the first key address always opens a new attempt, even straight after an abort. Cycles where the chip is deselected, or selected with neither a read nor a write, leave the attempt as it stands. While the sequencer reports busy, the detector ignores the bus and stays idle. The memory array and its data path are not part of this block, so ordinary reads are unaffected.

Top module: `store_seq_detect`

## Requirements
- R1: After reset, `store_req` is low and no key step counts as matched.
- R2: A read access is a cycle with `bus_en_n`=0, `bus_oe_n`=0 and `bus_we_n`=1. A cycle where the chip is deselected, or selected with `bus_oe_n`=1 and `bus_we_n`=1, neither advances nor aborts an attempt.
- R3: A read is counted once, in the first cycle it is active or in a cycle where its address changes. Holding a read on one address for several cycles counts as a single read.
- R4: The key is the read addresses 0x000, 0x555, 0x2AA, 0x7FF, 0x0F0 and 0x70F, in that order. When the sixth key read is counted at a clock edge, `store_req` is high for the cycle that follows that edge.
- R5: A counted read whose address is not the next key address aborts the attempt, so no request results from it.
- R6: A counted read of 0x000 always leaves the detector with exactly one step matched, including straight after an abort or partway through an attempt.
- R7: Any write access (`bus_en_n`=0, `bus_we_n`=0) resets the detector to no steps matched.
- R8: While `seq_busy` is high, bus activity is ignored and the detector returns to no steps matched. No request is raised for an edge at which `seq_busy` is high.
- R9: `store_req` is high for exactly one cycle. The detector then has no steps matched, so one more 0x70F read does not raise a second request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en_n | input | 1 | Chip enable of the memory bus, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | ADDR_W (11) | Byte address of the current access |
| seq_busy | input | 1 | Store sequencer is busy |
| store_req | output | 1 | One-cycle request to start a nonvolatile store |

## Verification
The bench builds the detector with its default 11-bit address and six-step key. With these values, every one of the 2048 addresses can be tried as the read at each of the six key positions: the matched key prefix is read first, then the probe address, then the rest of the key. This covers every wrong-address abort, every restart from 0x000, and every repeated address that a held read swallows. The expected result is simply whether the probe equals the key entry at its position. Directed runs then cover held reads, deselected and idle selected cycles, writes, busy, and the exact cycle and width of the request.

// File: rtl/store_seq_pkg.sv
package store_seq_pkg;

    localparam int KEY_STEPS = 6;
    localparam int KEY_W     = 11;

    // Read address expected at each step of the store key, in order
    function automatic logic [KEY_W-1:0] step_key(input int idx);
        logic [KEY_W-1:0] k;
        case (idx)
            0:       k = 11'h000;
            1:       k = 11'h555;
            2:       k = 11'h2AA;
            3:       k = 11'h7FF;
            4:       k = 11'h0F0;
            5:       k = 11'h70F;
            default: k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/store_seq_bus_decode.sv
module store_seq_bus_decode #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_evt,
    output logic              wr_evt
);

    typedef struct packed {
        logic              rd_act;
        logic [ADDR_W-1:0] addr;
    } trk_t;

    trk_t trk_d, trk_q;
    logic rd_now;

    always_comb begin
        rd_now       = !en_n && !oe_n && we_n;
        trk_d.rd_act = rd_now;
        trk_d.addr   = addr;
        // a new read starts on its first active cycle or on an address change
        rd_evt       = rd_now && (!trk_q.rd_act || (addr != trk_q.addr));
        wr_evt       = !en_n && !we_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

endmodule

// File: rtl/store_seq_match.sv
module store_seq_match #(
    parameter int ADDR_W    = 11,
    parameter int NUM_STEPS = store_seq_pkg::KEY_STEPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              rd_evt,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] addr,
    output logic              store_req
);

    localparam int STEP_W  = $clog2(NUM_STEPS + 1);
    localparam int HIT_LEN = 1 << STEP_W;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              req;
    } mstate_t;

    mstate_t st_d, st_q;
    logic [HIT_LEN-1:0] hit;

    // one comparator per key step; unused slots never match
    for (genvar i = 0; i < HIT_LEN; i++) begin : g_hit
        if (i < NUM_STEPS) begin : g_cmp
            assign hit[i] = (addr == ADDR_W'(store_seq_pkg::step_key(i)));
        end else begin : g_pad
            assign hit[i] = 1'b0;
        end
    end

    always_comb begin
        st_d.step = st_q.step;
        st_d.req  = 1'b0;
        if (busy || wr_evt) begin
            st_d.step = '0;
        end else if (rd_evt) begin
            if (hit[st_q.step]) begin
                if (st_q.step == LAST_STEP) begin
                    st_d.req  = 1'b1;
                    st_d.step = '0;
                end else begin
                    st_d.step = st_q.step + 1'b1;
                end
            end else if (hit[0]) begin
                st_d.step = STEP_W'(1);
            end else begin
                st_d.step = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign store_req = st_q.req;

endmodule

// File: rtl/store_seq_detect.sv
module store_seq_detect #(
    parameter int ADDR_W    = 11,
    parameter int NUM_STEPS = store_seq_pkg::KEY_STEPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              seq_busy,
    output logic              store_req
);

    logic rd_evt;
    logic wr_evt;

    store_seq_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_n   (bus_en_n),
        .oe_n   (bus_oe_n),
        .we_n   (bus_we_n),
        .addr   (bus_addr),
        .rd_evt (rd_evt),
        .wr_evt (wr_evt)
    );

    store_seq_match #(.ADDR_W(ADDR_W), .NUM_STEPS(NUM_STEPS)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (seq_busy),
        .rd_evt    (rd_evt),
        .wr_evt    (wr_evt),
        .addr      (bus_addr),
        .store_req (store_req)
    );

endmodule

// File: rtl/store_seq_detect_chk.sv
module store_seq_detect_chk #(
    parameter int ADDR_W    = 11,
    parameter int NUM_STEPS = store_seq_pkg::KEY_STEPS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en_n,
    input logic              bus_oe_n,
    input logic              bus_we_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              seq_busy,
    input logic              store_req
);

    localparam logic [ADDR_W-1:0] LAST_KEY = ADDR_W'(store_seq_pkg::step_key(NUM_STEPS - 1));

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req); // R9

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> !store_req); // R8

    AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_en_n && !bus_we_n) |=> !store_req); // R7

    AST_NON_READ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en_n || bus_oe_n) |=> !store_req); // R2

    AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_req) |-> $past(bus_addr) == LAST_KEY); // R4

endmodule

bind store_seq_detect store_seq_detect_chk #(.ADDR_W(ADDR_W), .NUM_STEPS(NUM_STEPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en_n  (bus_en_n),
    .bus_oe_n  (bus_oe_n),
    .bus_we_n  (bus_we_n),
    .bus_addr  (bus_addr),
    .seq_busy  (seq_busy),
    .store_req (store_req)
);

// File: tb/store_seq_detect_test.sv
module store_seq_detect_test;

    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en_n = 1'b1;
    logic          bus_oe_n = 1'b1;
    logic          bus_we_n = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          seq_busy = 1'b0;
    logic          store_req;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    int double_hi = 0;
    logic last_req = 1'b0;
    bit done = 1'b0;

    logic [AW-1:0] key [6] = '{11'h000, 11'h555, 11'h2AA, 11'h7FF, 11'h0F0, 11'h70F};

    always #2.5 clk = ~clk;

    store_seq_detect uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en_n  (bus_en_n),
        .bus_oe_n  (bus_oe_n),
        .bus_we_n  (bus_we_n),
        .bus_addr  (bus_addr),
        .seq_busy  (seq_busy),
        .store_req (store_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one bus cycle, then sample just after the edge
    task automatic bus(input logic en, input logic oe, input logic we, input logic [AW-1:0] a);
        bus_en_n = en; bus_oe_n = oe; bus_we_n = we; bus_addr = a;
        @(posedge clk);
        #1;
        if (store_req) pulses++;
        if (store_req && last_req) double_hi++;
        last_req = store_req;
    endtask

    task automatic rd(input logic [AW-1:0] a);  bus(1'b0, 1'b0, 1'b1, a); endtask
    task automatic gap();                        bus(1'b1, 1'b1, 1'b1, '0); endtask
    task automatic rdg(input logic [AW-1:0] a); rd(a); gap(); endtask
    task automatic wr(input logic [AW-1:0] a);  bus(1'b0, 1'b1, 1'b0, a); gap(); endtask

    task automatic keys(input int from, input int upto);
        for (int i = from; i <= upto; i++) rdg(key[i]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset low", int'(store_req), 0);
        rst_n = 1'b1;
        gap();
        // R1: reset leaves nothing matched; steps 2..6 alone raise nothing
        pulses = 0; keys(1, 5); check("R1 no prior steps", pulses, 0);

        // R4: full key, request exactly the cycle after the sixth read edge
        pulses = 0; keys(0, 4);
        check("R4 no early pulse", pulses, 0);
        rd(key[5]);
        check("R4 pulse after sixth read", int'(store_req), 1);
        gap();
        check("R9 pulse one cycle", int'(store_req), 0);

        // R9: another 0x70F right after the request raises nothing
        pulses = 0; rdg(key[5]); check("R9 idle after pulse", pulses, 0);
        pulses = 0; keys(0, 5); check("R9 fresh key works", pulses, 1);

        // R3: held reads counted once; address change inside a held read is a new read
        pulses = 0;
        rd(key[0]); rd(key[0]); rd(key[0]); rd(key[1]); rd(key[1]);
        rd(key[2]); rd(key[3]); rd(key[4]); rd(key[5]); rd(key[5]); gap();
        check("R3 held reads counted once", pulses, 1);

        // R2: deselected and idle selected cycles neither advance nor abort
        pulses = 0;
        rdg(key[0]); rdg(key[1]);
        bus(1'b1, 1'b0, 1'b1, key[2]); bus(1'b0, 1'b1, 1'b1, 11'h123);
        keys(2, 5);
        check("R2 non-accesses ignored", pulses, 1);
        pulses = 0;
        rdg(key[0]); rdg(key[1]);
        bus(1'b0, 1'b1, 1'b1, key[2]); gap();
        keys(3, 5);
        check("R2 oe high is not a read", pulses, 0);

        // R5: wrong address mid-key aborts
        pulses = 0; rdg(key[0]); rdg(key[1]); rdg(11'h123); keys(2, 5);
        check("R5 wrong address aborts", pulses, 0);

        // R6: 0x000 restarts mid-attempt and after an abort
        pulses = 0; rdg(key[0]); rdg(key[1]); keys(0, 5);
        check("R6 restart mid attempt", pulses, 1);
        pulses = 0; rdg(key[0]); rdg(key[0]); keys(1, 5);
        check("R6 repeated first key", pulses, 1);

        // R7: a write aborts, even to the expected address
        pulses = 0; keys(0, 1); wr(key[2]); keys(2, 5);
        check("R7 write aborts", pulses, 0);
        pulses = 0; wr(key[0]); keys(0, 5);
        check("R7 write then full key", pulses, 1);

        // R8: busy ignores the bus and clears progress
        pulses = 0; seq_busy = 1'b1; keys(0, 5); seq_busy = 1'b0; gap();
        check("R8 busy ignores bus", pulses, 0);
        pulses = 0; keys(0, 2); seq_busy = 1'b1; gap(); seq_busy = 1'b0; keys(3, 5);
        check("R8 busy clears progress", pulses, 0);
        pulses = 0; keys(0, 4); seq_busy = 1'b1; rd(key[5]); seq_busy = 1'b0; gap();
        check("R8 busy at last read", pulses, 0);

        // R5 R6 R3: sweep every address at every key position
        for (int k = 0; k < 6; k++) begin
            int bad = 0;
            for (int x = 0; x < (1 << AW); x++) begin
                pulses = 0;
                for (int i = 0; i < k; i++) rd(key[i]);
                rd(AW'(x));
                for (int i = k + 1; i < 6; i++) rd(key[i]);
                gap();
                if (pulses != ((AW'(x) == key[k]) ? 1 : 0)) begin
                    bad++;
                    if (bad == 1)
                        $display("FAIL R5 sweep step=%0d addr=%0h actual=%0d expected=%0d",
                                 k, x, pulses, (AW'(x) == key[k]) ? 1 : 0);
                end
                checks++;
            end
            failures += bad;
        end

        check("R9 no two-cycle pulse", double_hi, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule